// File: doc/BRIEF.md
# Neutral-Point Balancing Dwell-Time Corrector

This block sits between a three-level space-vector modulator and its gate sequencer. Once per modulation period it takes the dwell time the modulator has chosen for the medium vector and for the zero vectors. It also takes two estimated DC-link capacitor voltages and the polarity of the neutral-point current during the medium vector. It then moves a slice of time from the medium vector to the zero vectors, or from the zero vectors to the medium vector. The slice grows with the capacitor imbalance and with the medium dwell time. Its sign depends on which capacitor is higher and on the current polarity. The same rule holds in every sector.

The period start is marked by a one-cycle strobe. The block samples its inputs on that strobe and returns both corrected dwell times, with a valid pulse, a fixed three cycles later. A new strobe is accepted on every cycle. All arithmetic is unsigned or two's-complement fixed point. The gain product is formed at full width and then rounded to whole timer ticks. The corrected medium time is clamped so that neither output can go negative, and the two outputs always add up to the two inputs.

Top module: `np_dwell_adjust`

## Requirements
- R1: A high `start_i` at a rising clock edge samples all data inputs. `valid_o` is high for exactly one cycle, three rising edges later, and is never high otherwise. `t_med_o` and `t_zero_o` hold their last values on every cycle in which `valid_o` is low.
- R2: While `rst_ni` is low, `valid_o`, `t_med_o` and `t_zero_o` are all zero.
- R3: The correction magnitude in ticks is round(GAIN × |vc_hi_i − vc_lo_i| × t_med_i / 2^(GAIN_W+V_FRAC)), rounding halves up. Defaults are GAIN=51 and GAIN_W=8, a gain of about 0.2. V_FRAC=6 gives voltages of 1/64 V per LSB. As an example, 1 V of imbalance with t_med_i=1000 gives 199, and 0.5 V with t_med_i=256 gives exactly 25.5, which rounds to 26.
- R4: The correction is positive when vc_hi_i ≥ vc_lo_i and the current is non-negative (`inp_neg_i`=0), or when vc_hi_i < vc_lo_i and the current is negative (`inp_neg_i`=1). In every other case it is negative. A positive correction never raises the medium time, and a negative one never lowers it.
- R5: Before clamping, t_med_o = t_med_i − correction and t_zero_o = t_zero_i + correction.
- R6: t_med_o is clamped to the range 0 to t_med_i + t_zero_i. When the lower bound is hit, t_zero_o takes the whole sum; when the upper bound is hit, t_zero_o is 0.
- R7: On every valid output, t_med_o + t_zero_o equals t_med_i + t_zero_i of the matching sample, computed without overflow in T_W+1 bits.
- R8: Equal capacitor voltages give outputs equal to the inputs, whatever the current polarity.
- R9: Strobes on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Period-start strobe; samples the data inputs |
| vc_hi_i | input | V_W | Upper capacitor voltage estimate, signed, V_FRAC fractional bits |
| vc_lo_i | input | V_W | Lower capacitor voltage estimate, signed, V_FRAC fractional bits |
| inp_neg_i | input | 1 | 1 when the neutral-point current during the medium vector is negative |
| t_med_i | input | T_W | Medium-vector dwell time in ticks |
| t_zero_i | input | T_W | Zero-vector dwell time in ticks |
| valid_o | output | 1 | One-cycle pulse marking new outputs |
| t_med_o | output | T_W+1 | Corrected medium dwell time |
| t_zero_o | output | T_W+1 | Corrected zero dwell time |

## Verification
The hardest cases to reach are the two clamp edges and the exact half-tick rounding point. Random voltages rarely land there, so the bench drives directed inputs. A 10 V imbalance against a small zero time forces each clamp, once for each current polarity. A 0.5 V imbalance with a 256-tick medium time makes the scaled product land exactly on a half tick. After these directed cases, a long run of back-to-back strobes with gaps and full-range voltages is compared cycle by cycle against a behavioural model. That run covers the pipeline overlap and output hold.

// File: rtl/np_bal_pkg.sv
package np_bal_pkg;
  typedef enum logic {
    RND_TRUNC   = 1'b0,
    RND_HALF_UP = 1'b1
  } rnd_mode_e;

  localparam int unsigned PIPE_LAT = 3;
endpackage

// File: rtl/np_imbal_stage.sv
// Stage 1: capture on strobe, form |imbalance|, correction sign and period sum.
module np_imbal_stage #(
  parameter int unsigned V_W = 16,
  parameter int unsigned T_W = 16,
  localparam int unsigned D_W  = V_W + 1,
  localparam int unsigned TS_W = T_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic signed [V_W-1:0] vc_hi_i,
  input  logic signed [V_W-1:0] vc_lo_i,
  input  logic                  inp_neg_i,
  input  logic [T_W-1:0]        t_med_i,
  input  logic [T_W-1:0]        t_zero_i,
  output logic                  vld_o,
  output logic [D_W-1:0]        mag_o,
  output logic                  pos_o,
  output logic [T_W-1:0]        med_o,
  output logic [TS_W-1:0]       tot_o
);
  logic signed [D_W-1:0] diff;
  logic [D_W-1:0]        mag_d;
  logic                  pos_d;

  always_comb begin
    diff  = {vc_hi_i[V_W-1], vc_hi_i} - {vc_lo_i[V_W-1], vc_lo_i};
    mag_d = diff[D_W-1] ? D_W'(-diff) : D_W'(diff);
    // sgn(0) = +1, so a zero imbalance counts as non-negative
    pos_d = ~(diff[D_W-1] ^ inp_neg_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      mag_o <= '0;
      pos_o <= 1'b0;
      med_o <= '0;
      tot_o <= '0;
    end else begin
      vld_o <= start_i;
      if (start_i) begin
        mag_o <= mag_d;
        pos_o <= pos_d;
        med_o <= t_med_i;
        tot_o <= {1'b0, t_med_i} + {1'b0, t_zero_i};
      end
    end
  end
endmodule

// File: rtl/np_scale_stage.sv
// Stage 2: full-width gain product, reduced to integer ticks.
module np_scale_stage
  import np_bal_pkg::*;
#(
  parameter int unsigned V_W    = 16,
  parameter int unsigned T_W    = 16,
  parameter int unsigned V_FRAC = 6,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned GAIN   = 51,
  parameter rnd_mode_e   RND    = RND_HALF_UP,
  localparam int unsigned D_W    = V_W + 1,
  localparam int unsigned TS_W   = T_W + 1,
  localparam int unsigned PROD_W = GAIN_W + D_W + T_W,
  localparam int unsigned SHIFT  = GAIN_W + V_FRAC,
  localparam int unsigned MAG_W  = PROD_W - SHIFT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [D_W-1:0]    mag_i,
  input  logic              pos_i,
  input  logic [T_W-1:0]    med_i,
  input  logic [TS_W-1:0]   tot_i,
  output logic              vld_o,
  output logic [MAG_W-1:0]  dmag_o,
  output logic              pos_o,
  output logic [T_W-1:0]    med_o,
  output logic [TS_W-1:0]   tot_o
);
  logic [PROD_W-1:0] prod;
  logic [MAG_W-1:0]  dmag_d;

  assign prod = PROD_W'(GAIN) * PROD_W'(mag_i) * PROD_W'(med_i);

  generate
    if (RND == RND_HALF_UP) begin : g_round
      localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (SHIFT - 1);
      logic [PROD_W:0] rsum;
      assign rsum   = {1'b0, prod} + HALF;
      assign dmag_d = MAG_W'(rsum >> SHIFT);
    end else begin : g_trunc
      assign dmag_d = MAG_W'(prod >> SHIFT);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      dmag_o <= '0;
      pos_o  <= 1'b0;
      med_o  <= '0;
      tot_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        dmag_o <= dmag_d;
        pos_o  <= pos_i;
        med_o  <= med_i;
        tot_o  <= tot_i;
      end
    end
  end
endmodule

// File: rtl/np_apply_stage.sv
// Stage 3: signed correction, clamp, split the period.
module np_apply_stage #(
  parameter int unsigned T_W   = 16,
  parameter int unsigned MAG_W = 26,
  localparam int unsigned TS_W  = T_W + 1,
  localparam int unsigned RAW_W = ((MAG_W > TS_W) ? MAG_W : TS_W) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [MAG_W-1:0] dmag_i,
  input  logic             pos_i,
  input  logic [T_W-1:0]   med_i,
  input  logic [TS_W-1:0]  tot_i,
  output logic             valid_o,
  output logic [TS_W-1:0]  t_med_o,
  output logic [TS_W-1:0]  t_zero_o
);
  logic signed [RAW_W-1:0] base, corr, raw, lim;
  logic [TS_W-1:0]         med_n, zero_n;

  always_comb begin
    base = $signed(RAW_W'(med_i));
    lim  = $signed(RAW_W'(tot_i));
    corr = pos_i ? $signed(RAW_W'(dmag_i)) : -$signed(RAW_W'(dmag_i));
    raw  = base - corr;
    if (raw < 0)        med_n = '0;
    else if (raw > lim) med_n = tot_i;
    else                med_n = TS_W'(raw);
    zero_n = tot_i - med_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      t_med_o  <= '0;
      t_zero_o <= '0;
    end else begin
      valid_o <= vld_i;
      if (vld_i) begin
        t_med_o  <= med_n;
        t_zero_o <= zero_n;
      end
    end
  end
endmodule

// File: rtl/np_dwell_adjust.sv
module np_dwell_adjust
  import np_bal_pkg::*;
#(
  parameter int unsigned V_W    = 16,
  parameter int unsigned T_W    = 16,
  parameter int unsigned V_FRAC = 6,
  parameter int unsigned GAIN_W = 8,
  parameter int unsigned GAIN   = 51,
  parameter rnd_mode_e   RND    = RND_HALF_UP,
  localparam int unsigned D_W    = V_W + 1,
  localparam int unsigned TS_W   = T_W + 1,
  localparam int unsigned PROD_W = GAIN_W + D_W + T_W,
  localparam int unsigned MAG_W  = PROD_W - (GAIN_W + V_FRAC) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic signed [V_W-1:0] vc_hi_i,
  input  logic signed [V_W-1:0] vc_lo_i,
  input  logic                  inp_neg_i,
  input  logic [T_W-1:0]        t_med_i,
  input  logic [T_W-1:0]        t_zero_i,
  output logic                  valid_o,
  output logic [TS_W-1:0]       t_med_o,
  output logic [TS_W-1:0]       t_zero_o
);
  logic              s1_vld, s1_pos, s2_vld, s2_pos;
  logic [D_W-1:0]    s1_mag;
  logic [T_W-1:0]    s1_med, s2_med;
  logic [TS_W-1:0]   s1_tot, s2_tot;
  logic [MAG_W-1:0]  s2_dmag;

  np_imbal_stage #(.V_W(V_W), .T_W(T_W)) u_imbal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vc_hi_i  (vc_hi_i),
    .vc_lo_i  (vc_lo_i),
    .inp_neg_i(inp_neg_i),
    .t_med_i  (t_med_i),
    .t_zero_i (t_zero_i),
    .vld_o    (s1_vld),
    .mag_o    (s1_mag),
    .pos_o    (s1_pos),
    .med_o    (s1_med),
    .tot_o    (s1_tot)
  );

  np_scale_stage #(
    .V_W(V_W), .T_W(T_W), .V_FRAC(V_FRAC),
    .GAIN_W(GAIN_W), .GAIN(GAIN), .RND(RND)
  ) u_scale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (s1_vld),
    .mag_i (s1_mag),
    .pos_i (s1_pos),
    .med_i (s1_med),
    .tot_i (s1_tot),
    .vld_o (s2_vld),
    .dmag_o(s2_dmag),
    .pos_o (s2_pos),
    .med_o (s2_med),
    .tot_o (s2_tot)
  );

  np_apply_stage #(.T_W(T_W), .MAG_W(MAG_W)) u_apply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (s2_vld),
    .dmag_i  (s2_dmag),
    .pos_i   (s2_pos),
    .med_i   (s2_med),
    .tot_i   (s2_tot),
    .valid_o (valid_o),
    .t_med_o (t_med_o),
    .t_zero_o(t_zero_o)
  );
endmodule

// File: rtl/np_dwell_adjust_chk.sv
module np_dwell_adjust_chk #(
  parameter int unsigned V_W = 16,
  parameter int unsigned T_W = 16,
  localparam int unsigned TS_W = T_W + 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic signed [V_W-1:0] vc_hi_i,
  input logic signed [V_W-1:0] vc_lo_i,
  input logic                  inp_neg_i,
  input logic [T_W-1:0]        t_med_i,
  input logic [T_W-1:0]        t_zero_i,
  input logic                  valid_o,
  input logic [TS_W-1:0]       t_med_o,
  input logic [TS_W-1:0]       t_zero_o
);
  logic [1:0]      since_rst;
  logic            ready;
  logic [TS_W-1:0] med_x, tot_x, out_sum;
  logic            bal_x, shrink_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign ready    = (since_rst == 2'd3);
  assign med_x    = {1'b0, t_med_i};
  assign tot_x    = {1'b0, t_med_i} + {1'b0, t_zero_i};
  assign out_sum  = t_med_o + t_zero_o;
  assign bal_x    = (vc_hi_i == vc_lo_i);
  assign shrink_x = ((vc_hi_i >= vc_lo_i) == !inp_neg_i);

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##3 valid_o);

  p_no_spurious_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && valid_o) |-> $past(start_i, 3));

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(t_med_o) && $stable(t_zero_o)));

  p_sum_conserved_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && valid_o) |-> (out_sum == $past(tot_x, 3)));

  p_balanced_passthru_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(start_i && bal_x, 3)) |-> (t_med_o == $past(med_x, 3)));

  p_shrink_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(start_i && shrink_x, 3)) |-> (t_med_o <= $past(med_x, 3)));

  p_grow_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && $past(start_i && !shrink_x, 3)) |-> (t_med_o >= $past(med_x, 3)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r2: assert (!valid_o && t_med_o == '0 && t_zero_o == '0);
    end
  end
endmodule

bind np_dwell_adjust np_dwell_adjust_chk #(.V_W(V_W), .T_W(T_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .vc_hi_i  (vc_hi_i),
  .vc_lo_i  (vc_lo_i),
  .inp_neg_i(inp_neg_i),
  .t_med_i  (t_med_i),
  .t_zero_i (t_zero_i),
  .valid_o  (valid_o),
  .t_med_o  (t_med_o),
  .t_zero_o (t_zero_o)
);

// File: tb/np_dwell_adjust_tb.sv
`timescale 1ns/1ps
module np_dwell_adjust_tb;
  localparam int V_W = 16;
  localparam int T_W = 16;
  localparam int TS_W = T_W + 1;
  localparam real CLK_NS = 5.0;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  start_i = 1'b0;
  logic signed [V_W-1:0] vc_hi_i = '0;
  logic signed [V_W-1:0] vc_lo_i = '0;
  logic                  inp_neg_i = 1'b0;
  logic [T_W-1:0]        t_med_i = '0;
  logic [T_W-1:0]        t_zero_i = '0;
  logic                  valid_o;
  logic [TS_W-1:0]       t_med_o, t_zero_o;

  np_dwell_adjust u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .vc_hi_i(vc_hi_i), .vc_lo_i(vc_lo_i), .inp_neg_i(inp_neg_i),
    .t_med_i(t_med_i), .t_zero_i(t_zero_i),
    .valid_o(valid_o), .t_med_o(t_med_o), .t_zero_o(t_zero_o)
  );

  always #(CLK_NS / 2.0) clk_i = ~clk_i;

  typedef struct {
    bit      vld;
    longint  med;
    longint  zero;
    longint  tot;
    string   tag;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     failures = 0;
  bit     done = 1'b0;
  longint hold_med = 0, hold_zero = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural model of the requirements (R3..R6)
  function automatic exp_t model(input longint a, input longint b, input bit ng,
                                 input longint m, input longint z, input string tag);
    exp_t e;
    longint d, mag, p, c, raw, tot;
    bit pos;
    d   = a - b;
    mag = (d < 0) ? -d : d;
    p   = 51 * mag * m;
    c   = (p + 8192) / 16384;
    pos = ((d >= 0) == !ng);
    if (!pos) c = -c;
    tot = m + z;
    raw = m - c;
    if (raw < 0) raw = 0;
    if (raw > tot) raw = tot;
    e.vld = 1'b1; e.med = raw; e.zero = tot - raw; e.tot = tot; e.tag = tag;
    return e;
  endfunction

  task automatic step(input bit st, input int a, input int b, input bit ng,
                      input int m, input int z, input string tag);
    exp_t e, n;
    @(negedge clk_i);
    if (q.size() == 3) begin
      e = q.pop_front();
      if (e.vld) begin
        chk(valid_o == 1'b1, e.tag, "valid", longint'(valid_o), 1);
        chk(longint'(t_med_o) == e.med, e.tag, "t_med", longint'(t_med_o), e.med);
        chk(longint'(t_zero_o) == e.zero, e.tag, "t_zero", longint'(t_zero_o), e.zero);
        // R7: sum conserved
        chk(longint'(t_med_o) + longint'(t_zero_o) == e.tot, "R7", "sum",
            longint'(t_med_o) + longint'(t_zero_o), e.tot);
        hold_med = e.med; hold_zero = e.zero;
      end else begin
        // R1: no pulse, outputs held
        chk(valid_o == 1'b0, "R1", "idle valid", longint'(valid_o), 0);
        chk(longint'(t_med_o) == hold_med && longint'(t_zero_o) == hold_zero,
            "R1", "hold t_med", longint'(t_med_o), hold_med);
      end
    end
    start_i   = st;
    vc_hi_i   = V_W'(a);
    vc_lo_i   = V_W'(b);
    inp_neg_i = ng;
    t_med_i   = T_W'(m);
    t_zero_i  = T_W'(z);
    if (st) n = model(longint'(signed'(V_W'(a))), longint'(signed'(V_W'(b))), ng, m, z, tag);
    else begin n.vld = 1'b0; n.med = 0; n.zero = 0; n.tot = 0; n.tag = "R1"; end
    q.push_back(n);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0, 0, 0, "R1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000.0);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    // R2: reset state, even with a strobe present
    start_i = 1'b1; t_med_i = 16'd500; vc_hi_i = 16'sd100;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(valid_o == 1'b0 && t_med_o == '0 && t_zero_o == '0, "R2", "reset outputs",
          longint'(t_med_o) + longint'(valid_o), 0);
    end
    start_i = 1'b0;
    rst_ni  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      exp_t e0;
      e0.vld = 1'b0; e0.med = 0; e0.zero = 0; e0.tot = 0; e0.tag = "R1";
      q.push_back(e0);
    end

    // R8: balanced voltages pass through, both current polarities
    step(1, 12800, 12800, 0, 1000, 500, "R8");
    step(1, 12800, 12800, 1, 777, 2222, "R8");
    idle(2);
    // R3/R5: 1 V high side, positive current -> correction 199 (801 / 699)
    step(1, 12864, 12800, 0, 1000, 500, "R3");
    idle(1);
    // R4: negative current flips sign (1199 / 301)
    step(1, 12864, 12800, 1, 1000, 500, "R4");
    // R4: low side higher with negative current -> positive correction
    step(1, 12800, 12864, 1, 1000, 500, "R4");
    // R4: low side higher, positive current -> negative correction
    step(1, 12800, 12864, 0, 1000, 500, "R4");
    idle(3);
    // R3: exact half tick (0.5 V, 256 ticks -> 25.5 -> 26)
    step(1, 12832, 12800, 0, 256, 100, "R3");
    // R5: zero medium time gives no change
    step(1, 14000, 12000, 0, 0, 300, "R5");
    idle(2);
    // R6: clamp low (10 V, correction 1992 > 1000)
    step(1, 13440, 12800, 0, 1000, 500, "R6");
    // R6: clamp high (correction -1992, limit 1100)
    step(1, 13440, 12800, 1, 1000, 100, "R6");
    // R6/R7: full-scale periods
    step(1, 32767, -32768, 0, 65535, 65535, "R6");
    step(1, -32768, 32767, 0, 65535, 65535, "R6");
    idle(4);

    // R9: back-to-back strobes with occasional gaps, full-range values
    for (int i = 0; i < 400; i++) begin
      bit st;
      int a, b;
      st = ($urandom_range(0, 3) != 0);
      if (i % 3 == 0) begin
        a = $urandom_range(12000, 13600);
        b = $urandom_range(12000, 13600);
      end else begin
        a = int'($urandom_range(0, 65535)) - 32768;
        b = int'($urandom_range(0, 65535)) - 32768;
      end
      step(st, a, b, 1'($urandom_range(0, 1)),
           $urandom_range(0, 65535), $urandom_range(0, 65535), "R9");
    end
    idle(4);
    finish_run();
  end
endmodule